// File: doc/BRIEF.md
# Dual-Host Doorbell Bridge with Shared RAM

This block joins two processors on one clock: a network-side CPU and a main host. Each processor gets its own small register window and a window onto one shared on-chip RAM. A processor rings the other by clearing bit 0 of a doorbell register. The ring reaches the far side as an interrupt line, but only when the far side has opened its own gate bit. Every doorbell and gate bit is active low.

The host window also carries a fixed identification text and a reset output that the host can use to hold the network CPU in reset. Both windows show a ready flag, which rises one cycle after reset is released. The network window shows an 8-bit revision value. Both buses are simple synchronous buses with separate write and read strobes, and read data arrives one cycle after the read strobe. When the two ports write the same RAM word, or the same doorbell bit, in the same cycle, the network port wins.

Top module: `dbell_bridge`

## Requirements
- R1: During reset both interrupt outputs are high and the peer reset output is low. After reset every doorbell and gate bit reads 1, the peer reset bit reads 0, and the ready bit reads 1 on both windows.
- R2: Network window map, using bit 0 only, with upper bits reading 0: 0x00 rings the host, 0x04 shows and clears the host's ring, 0x08 is the gate for host rings (0 opens it), 0x0C is ready (reads 1 when running), and 0x10 returns REVISION in bits 7:0.
- R3: Host window map: words 0x00, 0x04 and 0x08 return the 10 ID characters, character i in byte lane i mod 4 of word i/4, and unused lanes read 0. 0x20 rings the network CPU, 0x24 shows and clears the network's ring, 0x28 is the gate for network rings, 0x2C is the peer reset bit, and 0x30 is ready.
- R4: `hostIrqN` goes low exactly when the network-to-host ring bit and the host gate bit are both 0. It is a registered level that follows the register state with one cycle of delay.
- R5: `netIrqN` goes low exactly when the host-to-network ring bit and the network gate bit are both 0. It is a registered level with one cycle of delay.
- R6: Each ring bit can be written from both windows (network 0x00 / host 0x24, host 0x20 / network 0x04). When both ports write the same ring bit in one cycle, the network value is kept.
- R7: `peerResetOut` equals host bit 0x2C. It changes only on a host write to 0x2C.
- R8: Network byte 0x2000+4k and host byte 0x10000+4k address the same RAM word, k taken modulo RAM_WORDS. The network window ends at 0x7FFF and the host window ends at 0x15FFF.
- R9: Read data appears on the cycle after the read strobe and holds until the next read. Unmapped offsets read 0. Writes to read-only registers have no effect.
- R10: When both ports write the same RAM word in one cycle, the network data is stored.
- R11: A read of a RAM word that is written in the same cycle, from either port, returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| netAddr | input | NET_AW | Network byte address |
| netWe | input | 1 | Network write strobe |
| netRe | input | 1 | Network read strobe |
| netWdata | input | 32 | Network write data |
| netRdata | output | 32 | Network read data, one cycle after netRe |
| netIrqN | output | 1 | Active-low interrupt to network CPU |
| hostAddr | input | HOST_AW | Host byte address |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, one cycle after hostRe |
| hostIrqN | output | 1 | Active-low interrupt to host |
| peerResetOut | output | 1 | Active-high reset for network CPU |

## Verification
The bench builds the bridge with RAM_WORDS set to 64 and a non-default revision value. This lets it write every RAM word from one window and read it back from the other. It also reaches the aliasing above the RAM depth by writing at host offsets 64 to 127 words into the window. All four combinations of ring bit and gate bit are swept in both directions, and each expected interrupt level is computed from the two bits. The same small setup makes it cheap to hit the same-cycle conflicts on the RAM words and the ring bits.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int unsigned BUS_W = 32;

  // network window register offsets
  localparam logic [31:0] N_RING_HOST = 32'h00;
  localparam logic [31:0] N_RING_SEEN = 32'h04;
  localparam logic [31:0] N_GATE      = 32'h08;
  localparam logic [31:0] N_UP        = 32'h0C;
  localparam logic [31:0] N_REV       = 32'h10;

  // host window register offsets
  localparam logic [31:0] H_RING_NET  = 32'h20;
  localparam logic [31:0] H_RING_SEEN = 32'h24;
  localparam logic [31:0] H_GATE      = 32'h28;
  localparam logic [31:0] H_PEER_RST  = 32'h2C;
  localparam logic [31:0] H_UP        = 32'h30;

  // strobes from control to the RAM datapath
  typedef struct packed {
    logic netWe;
    logic netRe;
    logic hostWe;
    logic hostRe;
    logic netSelRam;   // registered: network read data comes from RAM
    logic hostSelRam;  // registered: host read data comes from RAM
  } ramStrobe_t;

endpackage

// File: rtl/dbell_irq_line.sv
module dbell_irq_line (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  input  logic enN,
  output logic lineN
);

  always_ff @(posedge clk) begin
    if (!rstN) lineN <= 1'b1;
    else       lineN <= reqN | enN;
  end

  AST_IRQ_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (!reqN && !enN) |=> !lineN); // R4, R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    enN |=> lineN); // R4, R5

endmodule

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
#(
  parameter int unsigned NET_AW         = 15,
  parameter int unsigned HOST_AW        = 17,
  parameter int unsigned RAM_WORDS      = 1024,
  parameter logic [31:0] NET_RAM_BASE   = 32'h2000,
  parameter logic [31:0] NET_RAM_LAST   = 32'h7FFF,
  parameter logic [31:0] HOST_RAM_BASE  = 32'h10000,
  parameter logic [31:0] HOST_RAM_LAST  = 32'h15FFF,
  parameter logic [7:0]  REVISION       = 8'h21,
  parameter int unsigned ID_LEN         = 10,
  parameter logic [8*ID_LEN-1:0] ID_TEXT = "DBELLBRG01",
  localparam int unsigned RAM_AW        = $clog2(RAM_WORDS),
  localparam int unsigned ID_WORDS      = (ID_LEN + 3) / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NET_AW-1:0]  netAddr,
  input  logic              netWe,
  input  logic              netRe,
  input  logic              netWbit,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic              hostWbit,
  output ramStrobe_t        strobe,
  output logic [RAM_AW-1:0] netIdx,
  output logic [RAM_AW-1:0] hostIdx,
  output logic [BUS_W-1:0]  netRegQ,
  output logic [BUS_W-1:0]  hostRegQ,
  output logic              ringToHostN,
  output logic              ringToNetN,
  output logic              hostGateN,
  output logic              netGateN,
  output logic              peerReset
);

  logic [31:0] netOff, hostOff, netRel, hostRel;
  logic netInRam, hostInRam;
  logic readyQ, netSelRamQ, hostSelRamQ;
  logic nWrRingHost, nWrRingNet, nWrGate;
  logic hWrRingNet, hWrRingHost, hWrGate, hWrPeer;
  logic [BUS_W-1:0] netRegNext, hostRegNext;

  function automatic logic [7:0] idByte(int unsigned i);
    if (i < ID_LEN) return ID_TEXT[8*(ID_LEN-1-i) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [BUS_W-1:0] idWord(int unsigned w);
    logic [BUS_W-1:0] v;
    for (int unsigned b = 0; b < 4; b++) v[8*b +: 8] = idByte(4*w + b);
    return v;
  endfunction

  // address decode
  assign netOff    = 32'(netAddr) & ~32'h3;
  assign hostOff   = 32'(hostAddr) & ~32'h3;
  assign netInRam  = (netOff >= NET_RAM_BASE) && (netOff <= NET_RAM_LAST);
  assign hostInRam = (hostOff >= HOST_RAM_BASE) && (hostOff <= HOST_RAM_LAST);
  assign netRel    = (netOff - NET_RAM_BASE) >> 2;
  assign hostRel   = (hostOff - HOST_RAM_BASE) >> 2;
  assign netIdx    = netRel[RAM_AW-1:0];
  assign hostIdx   = hostRel[RAM_AW-1:0];

  assign nWrRingHost = netWe && !netInRam && (netOff == N_RING_HOST);
  assign nWrRingNet  = netWe && !netInRam && (netOff == N_RING_SEEN);
  assign nWrGate     = netWe && !netInRam && (netOff == N_GATE);
  assign hWrRingNet  = hostWe && !hostInRam && (hostOff == H_RING_NET);
  assign hWrRingHost = hostWe && !hostInRam && (hostOff == H_RING_SEEN);
  assign hWrGate     = hostWe && !hostInRam && (hostOff == H_GATE);
  assign hWrPeer     = hostWe && !hostInRam && (hostOff == H_PEER_RST);

  always_comb begin
    strobe.netWe      = netWe && netInRam;
    strobe.netRe      = netRe && netInRam;
    strobe.hostWe     = hostWe && hostInRam;
    strobe.hostRe     = hostRe && hostInRam;
    strobe.netSelRam  = netSelRamQ;
    strobe.hostSelRam = hostSelRamQ;
  end

  // register read muxes
  always_comb begin
    netRegNext = '0;
    if (!netInRam) begin
      case (netOff)
        N_RING_HOST: netRegNext[0]   = ringToHostN;
        N_RING_SEEN: netRegNext[0]   = ringToNetN;
        N_GATE:      netRegNext[0]   = netGateN;
        N_UP:        netRegNext[0]   = readyQ;
        N_REV:       netRegNext[7:0] = REVISION;
        default:     netRegNext      = '0;
      endcase
    end
  end

  always_comb begin
    hostRegNext = '0;
    if (!hostInRam) begin
      if (hostOff < 32'(ID_WORDS * 4)) begin
        hostRegNext = idWord(32'(hostOff >> 2));
      end else begin
        case (hostOff)
          H_RING_NET:  hostRegNext[0] = ringToNetN;
          H_RING_SEEN: hostRegNext[0] = ringToHostN;
          H_GATE:      hostRegNext[0] = hostGateN;
          H_PEER_RST:  hostRegNext[0] = peerReset;
          H_UP:        hostRegNext[0] = readyQ;
          default:     hostRegNext    = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringToHostN <= 1'b1;
      ringToNetN  <= 1'b1;
      hostGateN   <= 1'b1;
      netGateN    <= 1'b1;
      peerReset   <= 1'b0;
      readyQ      <= 1'b0;
      netRegQ     <= '0;
      hostRegQ    <= '0;
      netSelRamQ  <= 1'b0;
      hostSelRamQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      // network port has priority on each shared ring bit
      if (nWrRingHost)      ringToHostN <= netWbit;
      else if (hWrRingHost) ringToHostN <= hostWbit;
      if (nWrRingNet)       ringToNetN  <= netWbit;
      else if (hWrRingNet)  ringToNetN  <= hostWbit;
      if (nWrGate) netGateN  <= netWbit;
      if (hWrGate) hostGateN <= hostWbit;
      if (hWrPeer) peerReset <= hostWbit;
      if (netRe) begin
        netRegQ    <= netRegNext;
        netSelRamQ <= netInRam;
      end
      if (hostRe) begin
        hostRegQ    <= hostRegNext;
        hostSelRamQ <= hostInRam;
      end
    end
  end

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ); // R1
  AST_PEER_RST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !hWrPeer |=> $stable(peerReset)); // R7
  AST_RING_NET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (nWrRingNet && hWrRingNet) |=> (ringToNetN == $past(netWbit))); // R6
  AST_GATE_NET_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !nWrGate |=> $stable(netGateN)); // R9

endmodule

// File: rtl/dbell_ram.sv
module dbell_ram
  import dbell_pkg::*;
#(
  parameter int unsigned RAM_WORDS = 1024,
  localparam int unsigned RAM_AW   = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [RAM_AW-1:0] netIdx,
  input  logic [RAM_AW-1:0] hostIdx,
  input  logic [BUS_W-1:0]  netWdata,
  input  logic [BUS_W-1:0]  hostWdata,
  input  logic [BUS_W-1:0]  netRegQ,
  input  logic [BUS_W-1:0]  hostRegQ,
  output logic [BUS_W-1:0]  netRdata,
  output logic [BUS_W-1:0]  hostRdata
);

  logic [BUS_W-1:0] mem [RAM_WORDS];
  logic [BUS_W-1:0] netRamQ, hostRamQ;
  logic collide;

  assign collide = strobe.netWe && strobe.hostWe && (netIdx == hostIdx);

  // storage: host write suppressed on a same-word collision
  always_ff @(posedge clk) begin
    if (strobe.hostWe && !collide) mem[hostIdx] <= hostWdata;
    if (strobe.netWe)              mem[netIdx]  <= netWdata;
  end

  // read-first ports, data held between reads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      netRamQ  <= '0;
      hostRamQ <= '0;
    end else begin
      if (strobe.netRe)  netRamQ  <= mem[netIdx];
      if (strobe.hostRe) hostRamQ <= mem[hostIdx];
    end
  end

  assign netRdata  = strobe.netSelRam  ? netRamQ  : netRegQ;
  assign hostRdata = strobe.hostSelRam ? hostRamQ : hostRegQ;

  AST_NET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    collide |=> (mem[$past(netIdx)] == $past(netWdata))); // R10
  AST_NET_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.netRe |=> $stable(netRamQ)); // R9
  AST_HOST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hostRe |=> $stable(hostRamQ)); // R9

endmodule

// File: rtl/dbell_bridge.sv
module dbell_bridge
  import dbell_pkg::*;
#(
  parameter int unsigned NET_AW         = 15,
  parameter int unsigned HOST_AW        = 17,
  parameter int unsigned RAM_WORDS      = 1024,
  parameter logic [31:0] NET_RAM_BASE   = 32'h2000,
  parameter logic [31:0] NET_RAM_LAST   = 32'h7FFF,
  parameter logic [31:0] HOST_RAM_BASE  = 32'h10000,
  parameter logic [31:0] HOST_RAM_LAST  = 32'h15FFF,
  parameter logic [7:0]  REVISION       = 8'h21,
  parameter int unsigned ID_LEN         = 10,
  parameter logic [8*ID_LEN-1:0] ID_TEXT = "DBELLBRG01",
  localparam int unsigned RAM_AW        = $clog2(RAM_WORDS),
  localparam int unsigned N_LINES       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NET_AW-1:0]  netAddr,
  input  logic               netWe,
  input  logic               netRe,
  input  logic [31:0]        netWdata,
  output logic [31:0]        netRdata,
  output logic               netIrqN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  output logic               hostIrqN,
  output logic               peerResetOut
);

  ramStrobe_t        strobe;
  logic [RAM_AW-1:0] netIdx, hostIdx;
  logic [BUS_W-1:0]  netRegQ, hostRegQ;
  logic ringToHostN, ringToNetN, hostGateN, netGateN;
  logic [N_LINES-1:0] reqN, enN, lineN;

  dbell_ctrl #(
    .NET_AW(NET_AW), .HOST_AW(HOST_AW), .RAM_WORDS(RAM_WORDS),
    .NET_RAM_BASE(NET_RAM_BASE), .NET_RAM_LAST(NET_RAM_LAST),
    .HOST_RAM_BASE(HOST_RAM_BASE), .HOST_RAM_LAST(HOST_RAM_LAST),
    .REVISION(REVISION), .ID_LEN(ID_LEN), .ID_TEXT(ID_TEXT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .netAddr(netAddr), .netWe(netWe), .netRe(netRe), .netWbit(netWdata[0]),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostRe(hostRe), .hostWbit(hostWdata[0]),
    .strobe(strobe), .netIdx(netIdx), .hostIdx(hostIdx),
    .netRegQ(netRegQ), .hostRegQ(hostRegQ),
    .ringToHostN(ringToHostN), .ringToNetN(ringToNetN),
    .hostGateN(hostGateN), .netGateN(netGateN), .peerReset(peerResetOut)
  );

  dbell_ram #(.RAM_WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .netIdx(netIdx), .hostIdx(hostIdx),
    .netWdata(netWdata), .hostWdata(hostWdata),
    .netRegQ(netRegQ), .hostRegQ(hostRegQ),
    .netRdata(netRdata), .hostRdata(hostRdata)
  );

  // line 0: network rings host; line 1: host rings network
  assign reqN = {ringToNetN, ringToHostN};
  assign enN  = {netGateN, hostGateN};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    dbell_irq_line u_line (
      .clk(clk), .rstN(rstN), .reqN(reqN[g]), .enN(enN[g]), .lineN(lineN[g])
    );
  end

  assign hostIrqN = lineN[0];
  assign netIrqN  = lineN[1];

endmodule

// File: tb/dbell_bridge_bench.sv
module dbell_bridge_bench;

  localparam int unsigned RW = 64;
  localparam logic [7:0] REV = 8'h5C;
  localparam logic [79:0] IDT = "DBELLBRG01";

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [14:0] netAddr = '0;
  logic netWe = 1'b0, netRe = 1'b0;
  logic [31:0] netWdata = '0, netRdata;
  logic netIrqN;
  logic [16:0] hostAddr = '0;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic hostIrqN, peerResetOut;

  int nChecks = 0;
  int nBad = 0;
  string idStr = "DBELLBRG01";

  always #5 clk = ~clk;

  dbell_bridge #(.RAM_WORDS(RW), .REVISION(REV), .ID_TEXT(IDT)) u_dbell_bridge (
    .clk(clk), .rstN(rstN),
    .netAddr(netAddr), .netWe(netWe), .netRe(netRe), .netWdata(netWdata),
    .netRdata(netRdata), .netIrqN(netIrqN),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostRe(hostRe), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostIrqN(hostIrqN), .peerResetOut(peerResetOut)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one bus cycle on both ports; read data valid on return
  task automatic cyc(input logic nW, input logic nR, input logic [14:0] nA,
                     input logic [31:0] nD, input logic hW, input logic hR,
                     input logic [16:0] hA, input logic [31:0] hD);
    @(negedge clk);
    netWe = nW; netRe = nR; netAddr = nA; netWdata = nD;
    hostWe = hW; hostRe = hR; hostAddr = hA; hostWdata = hD;
    @(negedge clk);
    netWe = 0; netRe = 0; hostWe = 0; hostRe = 0;
  endtask

  task automatic nWr(input logic [14:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 0, '0, '0);
  endtask
  task automatic hWr(input logic [16:0] a, input logic [31:0] d);
    cyc(0, 0, '0, '0, 1, 0, a, d);
  endtask
  task automatic nRd(input logic [14:0] a, output logic [31:0] d);
    cyc(0, 1, a, '0, 0, 0, '0, '0); d = netRdata;
  endtask
  task automatic hRd(input logic [16:0] a, output logic [31:0] d);
    cyc(0, 0, '0, '0, 0, 1, a, '0); d = hostRdata;
  endtask

  function automatic logic [31:0] patA(int k);
    return 32'h5A000000 | (32'(k) << 8) | 32'(k * 3);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 hostIrqN in reset", 32'(hostIrqN), 1);
    check("R1 netIrqN in reset", 32'(netIrqN), 1);
    check("R1 peerResetOut in reset", 32'(peerResetOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values seen through both windows
    nRd(15'h00, d); check("R1 net ring-host", d, 1);
    nRd(15'h04, d); check("R1 net ring-seen", d, 1);
    nRd(15'h08, d); check("R1 net gate", d, 1);
    nRd(15'h0C, d); check("R1 R2 net ready", d, 1);
    hRd(17'h20, d); check("R1 host ring-net", d, 1);
    hRd(17'h24, d); check("R1 host ring-seen", d, 1);
    hRd(17'h28, d); check("R1 host gate", d, 1);
    hRd(17'h2C, d); check("R1 host peer rst", d, 0);
    hRd(17'h30, d); check("R1 R3 host ready", d, 1);
    // R2: revision, and R9 writes to read-only ignored
    nRd(15'h10, d); check("R2 revision", d, 32'(REV));
    nWr(15'h10, 32'hFFFF_FFFF); nWr(15'h0C, 0);
    nRd(15'h10, d); check("R9 revision after write", d, 32'(REV));
    nRd(15'h0C, d); check("R9 ready after write", d, 1);
    // R3: identification text
    for (int w = 0; w < 3; w++) begin
      e = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < 10) e[8*b +: 8] = idStr[4 * w + b];
      hRd(17'(4 * w), d); check("R3 id word", d, e);
    end
    // R9: unmapped reads and read data held
    nRd(15'h14, d); check("R9 net unmapped", d, 0);
    hRd(17'h40, d); check("R9 host unmapped", d, 0);
    hRd(17'h30, d);
    repeat (3) @(negedge clk);
    check("R9 host rdata held", hostRdata, 1);
    // R4: network rings host, host gate sweep
    for (int r = 0; r < 2; r++)
      for (int g = 0; g < 2; g++) begin
        nWr(15'h00, 32'(r));
        hWr(17'h28, 32'(g));
        @(negedge clk);
        check("R4 hostIrqN", 32'(hostIrqN), 32'(r | g));
        hRd(17'h24, d); check("R3 host sees ring", d, 32'(r));
      end
    // R5: host rings network, network gate sweep
    for (int r = 0; r < 2; r++)
      for (int g = 0; g < 2; g++) begin
        hWr(17'h20, 32'(r));
        nWr(15'h08, 32'(g));
        @(negedge clk);
        check("R5 netIrqN", 32'(netIrqN), 32'(r | g));
        nRd(15'h04, d); check("R2 net sees ring", d, 32'(r));
      end
    // R6: cross clear and same-cycle conflict
    nWr(15'h00, 0);
    hWr(17'h24, 1);
    nRd(15'h00, d); check("R6 host clears net ring", d, 1);
    cyc(1, 0, 15'h04, 32'h1, 1, 0, 17'h20, 32'h0);
    hRd(17'h20, d); check("R6 net wins ring-net", d, 1);
    cyc(1, 0, 15'h00, 32'h0, 1, 0, 17'h24, 32'h1);
    hRd(17'h24, d); check("R6 net wins ring-host", d, 0);
    // R7: peer reset
    hWr(17'h2C, 1);
    check("R7 peer reset high", 32'(peerResetOut), 1);
    nWr(15'h2C, 0);
    check("R7 net write no effect", 32'(peerResetOut), 1);
    hWr(17'h2C, 0);
    check("R7 peer reset low", 32'(peerResetOut), 0);
    // R8: full sweep net->host, then aliased host->net
    for (int k = 0; k < RW; k++) nWr(15'(32'h2000 + 4 * k), patA(k));
    for (int k = 0; k < RW; k++) begin
      hRd(17'(32'h10000 + 4 * k), d); check("R8 net to host", d, patA(k));
    end
    for (int k = 0; k < RW; k++) hWr(17'(32'h10000 + 4 * (k + RW)), ~patA(k));
    for (int k = 0; k < RW; k++) begin
      nRd(15'(32'h2000 + 4 * k), d); check("R8 aliased host to net", d, ~patA(k));
    end
    nWr(15'h7FFC, 32'hCAFE0001);
    hRd(17'(32'h10000 + 4 * ((32'h5FFC >> 2) % RW)), d);
    check("R8 net window top", d, 32'hCAFE0001);
    // R10: same-word collision, and distinct words both land
    cyc(1, 0, 15'h201C, 32'h11, 1, 0, 17'h1001C, 32'h22);
    hRd(17'h1001C, d); check("R10 collision net wins", d, 32'h11);
    cyc(1, 0, 15'h2020, 32'h33, 1, 0, 17'h10024, 32'h44);
    nRd(15'h2020, d); check("R10 distinct net", d, 32'h33);
    nRd(15'h2024, d); check("R10 distinct host", d, 32'h44);
    // R11: read during write returns old data
    nWr(15'h2014, 32'hAAAA);
    cyc(0, 1, 15'h2014, '0, 1, 0, 17'h10014, 32'hBBBB);
    check("R11 cross-port old", netRdata, 32'hAAAA);
    nRd(15'h2014, d); check("R11 new after", d, 32'hBBBB);
    cyc(0, 0, '0, '0, 1, 1, 17'h10014, 32'hCCCC);
    check("R11 same-port old", hostRdata, 32'hBBBB);
    hRd(17'h10014, d); check("R11 same-port new", d, 32'hCCCC);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule